// File: doc/BRIEF.md
# Self-Recovering Six-State Sequence Counter

This block is a 3-bit synchronous counter whose state bits, most significant first, are C, B and A. It does not count in binary. Instead, three direct next-state equations walk it through a fixed loop of six codes. All three flip-flops share one clock edge, so the bits never ripple. The sequence drives timing and control decisions that need a short repeating pattern of distinct codes.

Of the eight 3-bit codes, two are not on the loop: 110 and 111. The equations still define a successor for each of them, and both successors lie on the loop. A disturbed register therefore returns to the sequence after a single enabled clock, with no external help.

A synchronous reset loads a start code, and an enable input acts as a load control. The start code is a parameter with a default of 000. Other values are meant for bench builds and for starting the loop at a chosen phase.

Top module: `seq6_counter`

## Requirements
- R1: When `rst` is 1 at a rising clock edge, `state` becomes the parameter `INIT_STATE` (default 000) after that edge, whatever the value of `en`.
- R2: When `rst` is 0 and `en` is 1 at an edge, the new A (bit 0 of `state`) equals the old A XOR the old B (bit 1).
- R3: When `rst` is 0 and `en` is 1 at an edge, the new B (bit 1) equals the old C (bit 2).
- R4: When `rst` is 0 and `en` is 1 at an edge, the new C (bit 2) is 1 only if the old B and the old C were both 0.
- R5: Starting from 000 with `en` held at 1, `state` visits 100, 010, 001, 101, 011 in that order and then returns to 000. The period is six clocks.
- R6: With `en` at 1, the unused code 110 steps to 011.
- R7: With `en` at 1, the unused code 111 steps to 010.
- R8: When `rst` is 0 and `en` is 0 at an edge, `state` keeps its value.
- R9: After any enabled step, `state` is never 110 or 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state bits update on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. Loads `INIT_STATE`. |
| en | input | 1 | Step enable. When 0, the state is held. |
| state | output | 3 | Current code: bit 2 is C, bit 1 is B, bit 0 is A. |

## Verification
The bench builds three copies of the counter from the same clock, reset and enable.
- The first uses the default start code 000. It is used to walk the full loop, to test holding and to test reset priority.
- The second is built with `INIT_STATE` = 110.
- The third is built with `INIT_STATE` = 111.

The two unused codes cannot be reached through the ports of a correctly working counter. Building them in as reset values brings each one within reach, so the bench can check its one-clock recovery into the loop and the steps that follow.

// File: rtl/seq6_pkg.sv
package seq6_pkg;
  localparam int STATE_W = 3;
  localparam int BIT_A   = 0;
  localparam int BIT_B   = 1;
  localparam int BIT_C   = 2;

  typedef logic [STATE_W-1:0] code_t;

  // Codes off the six-state loop: C and B both set.
  function automatic logic is_off_loop(code_t s);
    return s[BIT_C] & s[BIT_B];
  endfunction
endpackage

// File: rtl/seq6_next.sv
module seq6_next
  import seq6_pkg::*;
(
  input  code_t cur,
  output code_t nxt
);
  // Direct per-bit equations; no incrementer.
  always_comb begin
    nxt        = '0;
    nxt[BIT_A] = cur[BIT_A] ^ cur[BIT_B];
    nxt[BIT_B] = cur[BIT_C];
    nxt[BIT_C] = ~cur[BIT_B] & ~cur[BIT_C];
  end
endmodule

// File: rtl/seq6_reg.sv
module seq6_reg
  import seq6_pkg::*;
#(
  parameter code_t INIT = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  code_t d,
  output code_t q
);
  // Single common edge; enable selects between new and held value.
  always_ff @(posedge clk) begin
    if (rst)     q <= INIT;
    else if (en) q <= d;
  end

  // R8: disabled clock edges leave the register unchanged
  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> $stable(q));

  // R1: reset loads the start code regardless of enable
  a_r1_reset_loads_init: assert property (@(posedge clk)
    rst |=> (q == INIT));
endmodule

// File: rtl/seq6_counter.sv
module seq6_counter
  import seq6_pkg::*;
#(
  parameter logic [STATE_W-1:0] INIT_STATE = 3'b000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  output logic [STATE_W-1:0] state
);
  code_t cur_q;
  code_t nxt_d;

  seq6_next u_next (
    .cur (cur_q),
    .nxt (nxt_d)
  );

  seq6_reg #(.INIT(INIT_STATE)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d   (nxt_d),
    .q   (cur_q)
  );

  assign state = cur_q;

  // R2: A follows A xor B
  a_r2_bit_a_step: assert property (@(posedge clk) disable iff (rst)
    en |=> (state[BIT_A] == ($past(state[BIT_A]) ^ $past(state[BIT_B]))));

  // R3: B takes old C
  a_r3_bit_b_step: assert property (@(posedge clk) disable iff (rst)
    en |=> (state[BIT_B] == $past(state[BIT_C])));

  // R4: C set only from B=0,C=0
  a_r4_bit_c_step: assert property (@(posedge clk) disable iff (rst)
    en |=> (state[BIT_C] == (!$past(state[BIT_B]) && !$past(state[BIT_C]))));

  // R9: an enabled step always lands on the loop
  a_r9_lands_on_loop: assert property (@(posedge clk) disable iff (rst)
    en |=> !is_off_loop(state));
endmodule

// File: tb/tb_seq6_counter.sv
module tb_seq6_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [2:0] st_main, st_u6, st_u7;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  seq6_counter #(.INIT_STATE(3'b000)) dut    (.clk(clk), .rst(rst), .en(en), .state(st_main));
  seq6_counter #(.INIT_STATE(3'b110)) dut_u6 (.clk(clk), .rst(rst), .en(en), .state(st_u6));
  seq6_counter #(.INIT_STATE(3'b111)) dut_u7 (.clk(clk), .rst(rst), .en(en), .state(st_u7));

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Drive at falling edge, sample 1 ns after the rising edge.
  task automatic tick(input logic r, input logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    tick(1'b1, 1'b0);
    chk("R1 reset default", st_main, 3'b000);
  endtask

  task automatic t_full_cycle;
    logic [2:0] seq [6] = '{3'b100, 3'b010, 3'b001, 3'b101, 3'b011, 3'b000};
    tick(1'b1, 1'b0);
    for (int i = 0; i < 12; i++) begin
      tick(1'b0, 1'b1);
      chk("R5 loop order", st_main, seq[i % 6]);
    end
    // Per-bit rules across 010 -> 001 and 001 -> 101
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    chk("R3 B from C / R4 C clear", st_main, 3'b010);
    tick(1'b0, 1'b1);
    chk("R2 A = A xor B", st_main, 3'b001);
    tick(1'b0, 1'b1);
    chk("R4 C set from B=C=0", st_main, 3'b101);
  endtask

  task automatic t_hold;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    tick(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      tick(1'b0, 1'b0);
      chk("R8 hold with en=0", st_main, 3'b010);
    end
    tick(1'b0, 1'b1);
    chk("R8 resume after hold", st_main, 3'b001);
  endtask

  task automatic t_reset_priority;
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    chk("R1 reset beats enable", st_main, 3'b000);
    chk("R1 reset code 110", st_u6, 3'b110);
    chk("R1 reset code 111", st_u7, 3'b111);
  endtask

  task automatic t_unused_110;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    chk("R8 unused 110 held", st_u6, 3'b110);
    tick(1'b0, 1'b1);
    chk("R6 110 -> 011", st_u6, 3'b011);
    tick(1'b0, 1'b1);
    chk("R9 after 110 rejoins loop", st_u6, 3'b000);
    tick(1'b0, 1'b1);
    chk("R5 continues after 110", st_u6, 3'b100);
  endtask

  task automatic t_unused_111;
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b1);
    chk("R7 111 -> 010", st_u7, 3'b010);
    tick(1'b0, 1'b1);
    chk("R9 after 111 rejoins loop", st_u7, 3'b001);
    tick(1'b0, 1'b1);
    chk("R5 continues after 111", st_u7, 3'b101);
  endtask

  initial begin
    t_reset();
    t_full_cycle();
    t_hold();
    t_reset_priority();
    t_unused_110();
    t_unused_111();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule